// File: doc/BRIEF.md
# Dual-Clock Phase Aligner with Orbit Gate

This block brings a counter on the doubled ADC clock and a counter on the doubled RF clock to a fixed phase relationship. No PLL divider is reset to do this. A single capture flop runs on the RF clock and samples a reference clock at 8/7 of the RF frequency. The captured level beats at one seventh of RF. Each rising edge of the beat is carried into both counter domains through a two-flop synchroniser and an edge detector. Each domain then gets a single-cycle clear. Because the beat period equals 8 ADC-side cycles and 14 RF-side cycles, every clear after the first lands on a counter wrap. From then on the zeros of the two counters recur at fixed, predictable instants.

On the RF-side clock, a pair of orbit counters walks through the slots of one revolution. One slot lasts one full RF-side counter cycle. The counters flag each slot as a bunch or a gap, and they raise a revolution marker at the first slot. A small state machine (states `G_IDLE`, `G_WAIT`, `G_PULSE`) starts on the marker and emits a gate pulse after a delay set by two fields. The coarse field counts whole slots and the fine field counts single RF-side cycles. Transitions: `G_IDLE`→`G_WAIT` on the marker, `G_WAIT`→`G_PULSE` when the delay count is exhausted, and `G_PULSE`→`G_IDLE` when the pulse length is done.

Top module: `phase_gate_top`

## Requirements
- R1: While `rst_n` is low, `adc_phase`, `rf_phase`, `locked`, `adc_locked`, `rev_mark` and `gate` are all zero.
- R2: `adc_phase` advances by one modulo 8 on every `clk_adc2` rising edge. `rf_phase` advances by one modulo 14 on every `clk_rf2` rising edge.
- R3: `ref_in` is captured on each rising edge of `clk_rf`. Each rising edge of the captured level produces exactly one single-cycle clear in each counter domain, after a two-flop synchroniser. The counter reads 0 in the cycle after its clear.
- R4: `locked` (RF side) and `adc_locked` (ADC side) go high after the first clear in their domain and stay high. Every later clear arrives while the counter holds its last value (13 or 7), so the count sequence is undisturbed.
- R5: Once aligned, zeros of `adc_phase` and `rf_phase` each recur every 70 ns. The time from an `adc_phase` zero to the next `rf_phase` zero is the same every period.
- R6: A slot begins when `rf_phase` returns to 0. Slots are numbered 0 to 11 from the revolution marker. `is_bunch` is 1 when (slot mod 4) < 3 and 0 otherwise.
- R7: `rev_mark` is high for exactly the one `clk_rf2` cycle in which slot 0 begins, only while `locked`. It therefore recurs every 168 cycles.
- R8: With D = 14·`coarse_sel` + `fine_sel`, `gate` rises D+2 `clk_rf2` cycles after the `rev_mark` cycle and stays high for 2 cycles.
- R9: `coarse_sel` and `fine_sel` are latched in the `rev_mark` cycle. Changes after that cycle do not move the pending gate; they take effect at the next marker.
- R10: `gate` is never high in a `rev_mark` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rf | input | 1 | RF clock; clocks the capture flop |
| clk_rf2 | input | 1 | Doubled RF clock; RF-side counter, orbit counters, gate |
| clk_adc2 | input | 1 | Doubled ADC clock; ADC-side counter |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| ref_in | input | 1 | Reference clock at 8/7 of RF |
| coarse_sel | input | 3 | Gate delay in whole slots (14 cycles each) |
| fine_sel | input | 4 | Gate delay in single `clk_rf2` cycles |
| adc_phase | output | 3 | Modulo-8 ADC-side counter |
| rf_phase | output | 4 | Modulo-14 RF-side counter |
| adc_locked | output | 1 | ADC-side counter has been aligned |
| locked | output | 1 | RF-side counter has been aligned |
| is_bunch | output | 1 | Current slot holds a bunch |
| rev_mark | output | 1 | First cycle of slot 0 |
| gate | output | 1 | Delayed gate pulse |

## Verification
A clear shows up as a 0 on the counter in the cycle after the edge detector fires. The edge detector fires two cycles after the captured level changes. The bench therefore does not predict the absolute first zero; it checks the periodic zero instants once both `locked` flags are high. The gate is due D+2 `clk_rf2` cycles after the marker. The bench counts falling edges from the falling edge in which it sees `rev_mark` and expects the first high `gate` at exactly that count. All outputs are sampled on falling edges of their own domain clock, which never coincide with the edges of the other clocks in the bench.

// File: rtl/phase_gate_pkg.sv
`timescale 1ns/1ps
package phase_gate_pkg;
    typedef enum logic [1:0] {G_IDLE, G_WAIT, G_PULSE} gate_state_e;

    function automatic int cw(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/sync_rise_pulse.sv
`timescale 1ns/1ps
module sync_rise_pulse #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic pulse
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], din};
    end

    always_comb pulse = sh[STAGES-1] & ~sh[STAGES];

    // R3: a clear lasts exactly one cycle
    p_clear_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/phase_counter.sv
`timescale 1ns/1ps
module phase_counter import phase_gate_pkg::*; #(
    parameter int MOD = 14,
    parameter int W   = cw(MOD)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt,
    output logic         locked
);
    localparam logic [W-1:0] LAST = W'(MOD - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            locked <= 1'b0;
        end else begin
            if (clr || cnt == LAST) cnt <= '0;
            else                    cnt <= cnt + 1'b1;
            if (clr) locked <= 1'b1;
        end
    end

    // R4: once aligned, every later clear falls on the wrap
    p_clear_on_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && locked) |-> (cnt == LAST));
endmodule

// File: rtl/orbit_tracker.sv
`timescale 1ns/1ps
module orbit_tracker import phase_gate_pkg::*; #(
    parameter int MOD_B     = 14,
    parameter int GROUP_LEN = 4,
    parameter int GROUPS    = 3,
    parameter int BUNCHES   = 3,
    parameter int PW        = cw(MOD_B)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          locked,
    input  logic [PW-1:0] rf_phase,
    output logic          is_bunch,
    output logic          rev_mark
);
    localparam int POSW = cw(GROUP_LEN);
    localparam int GRPW = cw(GROUPS);
    localparam logic [PW-1:0]   PH_LAST  = PW'(MOD_B - 1);
    localparam logic [POSW-1:0] POS_LAST = POSW'(GROUP_LEN - 1);
    localparam logic [GRPW-1:0] GRP_LAST = GRPW'(GROUPS - 1);

    logic [POSW-1:0] pos;
    logic [GRPW-1:0] grp;
    logic            slot_end;

    always_comb slot_end = (rf_phase == PH_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos <= '0;
            grp <= '0;
        end else if (slot_end) begin
            if (pos == POS_LAST) begin
                pos <= '0;
                grp <= (grp == GRP_LAST) ? '0 : grp + 1'b1;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

    always_comb begin
        is_bunch = (pos < POSW'(BUNCHES));
        rev_mark = locked && (rf_phase == '0) && (pos == '0) && (grp == '0);
    end

    // R6: slot 0 always holds a bunch
    p_mark_on_bunch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rev_mark |-> is_bunch);
endmodule

// File: rtl/gate_fsm.sv
`timescale 1ns/1ps
module gate_fsm import phase_gate_pkg::*; #(
    parameter int MOD_B    = 14,
    parameter int CW       = 3,
    parameter int FW       = 4,
    parameter int GATE_LEN = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rev_mark,
    input  logic [CW-1:0] coarse,
    input  logic [FW-1:0] fine,
    output logic          gate
);
    localparam int MAXD = (2**CW - 1) * MOD_B + 2**FW - 1;
    localparam int DW   = cw(MAXD + 1);
    localparam int LW   = cw(GATE_LEN);

    gate_state_e   state, nxt;
    logic [DW-1:0] dly;
    logic [LW-1:0] len;
    logic [DW-1:0] target;

    always_comb target = DW'(coarse) * DW'(MOD_B) + DW'(fine);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= G_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            G_IDLE:  if (rev_mark)  nxt = G_WAIT;
            G_WAIT:  if (dly == '0) nxt = G_PULSE;
            G_PULSE: if (len == '0) nxt = G_IDLE;
            default: nxt = G_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly <= '0;
            len <= '0;
        end else begin
            unique case (state)
                G_IDLE:  if (rev_mark) dly <= target;
                G_WAIT:  if (dly != '0) dly <= dly - 1'b1;
                         else           len <= LW'(GATE_LEN - 1);
                G_PULSE: if (len != '0) len <= len - 1'b1;
                default: ;
            endcase
        end
    end

    always_comb gate = (state == G_PULSE);

    // R10: the gate never overlaps the revolution marker
    p_gate_off_at_mark_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rev_mark |-> !gate);
endmodule

// File: rtl/phase_gate_top.sv
`timescale 1ns/1ps
module phase_gate_top import phase_gate_pkg::*; #(
    parameter int MOD_A     = 8,
    parameter int MOD_B     = 14,
    parameter int GROUP_LEN = 4,
    parameter int GROUPS    = 3,
    parameter int BUNCHES   = 3,
    parameter int CW        = 3,
    parameter int FW        = 4,
    parameter int GATE_LEN  = 2,
    parameter int AW        = cw(MOD_A),
    parameter int BW        = cw(MOD_B)
) (
    input  logic          clk_rf,
    input  logic          clk_rf2,
    input  logic          clk_adc2,
    input  logic          rst_n,
    input  logic          ref_in,
    input  logic [CW-1:0] coarse_sel,
    input  logic [FW-1:0] fine_sel,
    output logic [AW-1:0] adc_phase,
    output logic [BW-1:0] rf_phase,
    output logic          adc_locked,
    output logic          locked,
    output logic          is_bunch,
    output logic          rev_mark,
    output logic          gate
);
    logic beat;
    logic clr_adc, clr_rf;

    always_ff @(posedge clk_rf or negedge rst_n) begin
        if (!rst_n) beat <= 1'b0;
        else        beat <= ref_in;
    end

    sync_rise_pulse #(.STAGES(2)) u_sync_adc (
        .clk(clk_adc2), .rst_n(rst_n), .din(beat), .pulse(clr_adc));
    sync_rise_pulse #(.STAGES(2)) u_sync_rf (
        .clk(clk_rf2), .rst_n(rst_n), .din(beat), .pulse(clr_rf));

    phase_counter #(.MOD(MOD_A), .W(AW)) u_cnt_adc (
        .clk(clk_adc2), .rst_n(rst_n), .clr(clr_adc),
        .cnt(adc_phase), .locked(adc_locked));
    phase_counter #(.MOD(MOD_B), .W(BW)) u_cnt_rf (
        .clk(clk_rf2), .rst_n(rst_n), .clr(clr_rf),
        .cnt(rf_phase), .locked(locked));

    orbit_tracker #(.MOD_B(MOD_B), .GROUP_LEN(GROUP_LEN), .GROUPS(GROUPS),
                    .BUNCHES(BUNCHES), .PW(BW)) u_orbit (
        .clk(clk_rf2), .rst_n(rst_n), .locked(locked), .rf_phase(rf_phase),
        .is_bunch(is_bunch), .rev_mark(rev_mark));

    gate_fsm #(.MOD_B(MOD_B), .CW(CW), .FW(FW), .GATE_LEN(GATE_LEN)) u_gate (
        .clk(clk_rf2), .rst_n(rst_n), .rev_mark(rev_mark),
        .coarse(coarse_sel), .fine(fine_sel), .gate(gate));
endmodule

// File: tb/tb_phase_gate_top.sv
`timescale 1ns/1ps
module tb_phase_gate_top;
    logic clk_rf = 0, clk_rf2 = 0, clk_adc2 = 0, ref_in = 0;
    logic rst_n = 0;
    logic [2:0] coarse_sel = 0;
    logic [3:0] fine_sel = 0;
    logic [2:0] adc_phase;
    logic [3:0] rf_phase;
    logic adc_locked, locked, is_bunch, rev_mark, gate;

    phase_gate_top dut (
        .clk_rf(clk_rf), .clk_rf2(clk_rf2), .clk_adc2(clk_adc2), .rst_n(rst_n),
        .ref_in(ref_in), .coarse_sel(coarse_sel), .fine_sel(fine_sel),
        .adc_phase(adc_phase), .rf_phase(rf_phase), .adc_locked(adc_locked),
        .locked(locked), .is_bunch(is_bunch), .rev_mark(rev_mark), .gate(gate));

    // 200 MHz doubled RF clock, 100 MHz RF, 8/7 reference and ADC-side clock
    initial forever #2.5 clk_rf2 = ~clk_rf2;
    initial forever #5.0 clk_rf = ~clk_rf;
    initial begin #1.3;  forever begin ref_in = ~ref_in; #4.375; end end
    initial begin #0.55; forever begin clk_adc2 = ~clk_adc2; #4.375; end end

    localparam int NV = 8;
    localparam int VC [NV] = '{0, 0, 1, 2, 3, 5, 7, 7};
    localparam int VF [NV] = '{0, 5, 0, 13, 7, 1, 0, 13};

    int checks = 0, fails = 0;
    int a_chk = 0, a_fail = 0, r_chk = 0, r_fail = 0, wd_fail = 0;
    bit mon_on = 0, done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        int tot, bad;
        tot = checks + a_chk + r_chk + wd_fail;
        bad = fails + a_fail + r_fail + wd_fail;
        $display("%0d/%0d checks passed", tot - bad, tot);
    endtask

    // ADC-side monitor: R2 stepping, R5 zero period
    int  a_prev = 0;
    real ta = 0.0;
    bit  have_a = 0;
    always @(negedge clk_adc2) begin
        if (mon_on) begin
            a_chk++;
            if (int'(adc_phase) != (a_prev + 1) % 8) begin
                a_fail++;
                $display("FAIL R2 adc step actual=%0d expected=%0d", adc_phase, (a_prev + 1) % 8);
            end
            if (adc_phase == 0) begin
                if (have_a) begin
                    a_chk++;
                    if ($realtime - ta > 70.01 || $realtime - ta < 69.99) begin
                        a_fail++;
                        $display("FAIL R5 adc zero period actual=%0d expected=%0d",
                                 int'(($realtime - ta) * 1000), 70000);
                    end
                end
                ta = $realtime;
                have_a = 1;
            end
        end
        a_prev = int'(adc_phase);
    end

    // RF-side monitor: R2, R5 offset, R6 bunch pattern, R7 marker
    int  r_prev = 0, slot = 0, rev_gap = 0;
    real tr = 0.0, ofs = 0.0;
    bit  have_r = 0, have_ofs = 0, have_rev = 0;
    always @(negedge clk_rf2) begin
        rev_gap++;
        if (mon_on) begin
            r_chk++;
            if (int'(rf_phase) != (r_prev + 1) % 14) begin
                r_fail++;
                $display("FAIL R2 rf step actual=%0d expected=%0d", rf_phase, (r_prev + 1) % 14);
            end
            if (rf_phase == 0) begin
                if (have_r) begin
                    r_chk++;
                    if ($realtime - tr > 70.01 || $realtime - tr < 69.99) begin
                        r_fail++;
                        $display("FAIL R5 rf zero period actual=%0d expected=%0d",
                                 int'(($realtime - tr) * 1000), 70000);
                    end
                end
                tr = $realtime;
                have_r = 1;
                if (have_a) begin
                    if (have_ofs) begin
                        r_chk++;
                        if ($realtime - ta - ofs > 0.01 || $realtime - ta - ofs < -0.01) begin
                            r_fail++;
                            $display("FAIL R5 zero offset actual=%0d expected=%0d",
                                     int'(($realtime - ta) * 1000), int'(ofs * 1000));
                        end
                    end else begin
                        ofs = $realtime - ta;
                        have_ofs = 1;
                    end
                end
                if (have_rev) begin
                    slot = (slot + 1) % 12;
                    r_chk++;
                    if (rev_mark != (slot == 0)) begin
                        r_fail++;
                        $display("FAIL R7 marker at slot actual=%0d expected=%0d", rev_mark, slot == 0);
                    end
                end else if (rev_mark) begin
                    have_rev = 1;
                    slot = 0;
                end
            end else if (rev_mark) begin
                r_chk++; r_fail++;
                $display("FAIL R7 marker off slot start actual=%0d expected=%0d", rf_phase, 0);
            end
            if (rev_mark && have_rev && rev_gap != 0) begin
                r_chk++;
                if (rev_gap != 168) begin
                    r_fail++;
                    $display("FAIL R7 marker period actual=%0d expected=%0d", rev_gap, 168);
                end
            end
            if (have_rev) begin
                r_chk++;
                if (is_bunch != ((slot % 4) < 3)) begin
                    r_fail++;
                    $display("FAIL R6 slot %0d actual=%0d expected=%0d", slot, is_bunch, (slot % 4) < 3);
                end
            end
        end
        if (rev_mark) rev_gap = 0;
        r_prev = int'(rf_phase);
    end

    task automatic wait_mark();
        do @(negedge clk_rf2); while (!rev_mark);
    endtask

    // count falling edges from the marker until gate is high, then its width
    task automatic measure(input int exp_d, input string req);
        int n = 0, w = 0;
        do begin @(negedge clk_rf2); n++; end while (!gate && n < 400);
        check(n == exp_d, req, n, exp_d);
        do begin @(negedge clk_rf2); w++; end while (gate && w < 50);
        check(w == 2, "R8 width", w, 2);
    endtask

    initial begin
        repeat (4) @(negedge clk_rf2);
        // R1 reset state
        check(adc_phase == 0 && rf_phase == 0, "R1 counters", rf_phase, 0);
        check(!locked && !adc_locked, "R1 lock flags", locked + adc_locked, 0);
        check(!gate && !rev_mark, "R1 gate/marker", gate + rev_mark, 0);
        rst_n = 1;
        repeat (40) @(negedge clk_rf2);
        // R4 / R3: first clear seen in both domains
        check(locked == 1, "R4 rf locked", locked, 1);
        check(adc_locked == 1, "R4 adc locked", adc_locked, 1);
        repeat (60) @(negedge clk_rf2);
        mon_on = 1;

        // R8: table of coarse/fine settings
        for (int i = 0; i < NV; i++) begin
            coarse_sel = 3'(VC[i]);
            fine_sel   = 4'(VF[i]);
            wait_mark();
            measure(VC[i] * 14 + VF[i] + 2, "R8 delay");
        end

        // R9: change settings after the marker
        coarse_sel = 3'd2; fine_sel = 4'd3;
        wait_mark();
        repeat (3) @(negedge clk_rf2);
        coarse_sel = 3'd6; fine_sel = 4'd9;
        begin
            int n = 3;
            do begin @(negedge clk_rf2); n++; end while (!gate && n < 400);
            check(n == 2 * 14 + 3 + 2, "R9 latched delay", n, 33);
        end
        wait_mark();
        measure(6 * 14 + 9 + 2, "R9 next marker");

        repeat (400) @(negedge clk_rf2);
        check(r_chk > 100 && a_chk > 100, "R5 monitors active", r_chk, 100);
        mon_on = 0;
        done = 1;
        summary();
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            wd_fail = 1;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
            $finish;
        end
    end
endmodule